// File: doc/BRIEF.md
# Transfer Status and Interrupt Logic

This block keeps the status of one DMA channel in a disk adapter and raises the level interrupt request to the CPU. It holds a transfer-busy flag, a transfer-complete flag, one ready flag per drive, and a vector of sticky adapter error bits. It also decides, in the same cycle as a command strobe, whether that command is accepted.

A data-transfer command needs its target drive to be ready and the channel to be idle. Once it is accepted, the channel turns busy and that drive stops being ready. The transfer ends once the byte count has reached zero. A read ends when the final word has been delivered to memory. A write ends at the end of the sector being written. A transfer also ends on an abort request. When a transfer ends, busy clears, complete sets and the drive's ready flag returns.

Software clears the status bits by writing ones to them. The interrupt request stays asserted as long as interrupts are enabled and some cause is still present.

Top module: `xfer_status_irq`

## Requirements
- R1: After reset, busy and complete are 0, every drive ready flag is 1, all error bits are 0 and the interrupt request is 0.
- R2: `cmdAccept` is combinational. A data command (`cmdIsData`=1) is accepted only when the target drive is ready and no transfer is busy. A non-data command is accepted whenever the target drive is ready, even while a transfer is busy. Accepting a non-data command changes no status.
- R3: On the clock edge that accepts a data command, busy sets, the target drive's ready flag clears, complete clears and every error bit clears.
- R4: A read (`cmdIsRead`=1) ends on the first cycle in which `lastWordSent` is high, provided byte-count-zero has been seen in that cycle or earlier. A write ends in the same way on `sectorEnd`. The end signal of the other direction is ignored. On the ending edge, busy clears, complete sets and the drive's ready flag sets.
- R5: An end-of-transfer pulse that arrives before byte-count-zero has been seen leaves the transfer running.
- R6: `abortReq` while busy ends the transfer in the same way as R4 and keeps the error bits. While idle, it has no effect.
- R7: `initReq` clears busy, complete and all error bits, sets every ready flag, and blocks command acceptance in its cycle. It takes priority over every other input.
- R8: Error events set their bits, and the bits stay set. Writing with `errClrWe` clears the bits selected by `errClrMask`. An event that arrives in the same cycle as the clear of its bit leaves the bit set.
- R9: `doneClrWe` clears complete. A termination in the same cycle leaves complete set.
- R10: `irqReq` equals `irqEnable` AND (complete OR any `attnIn` bit OR any error bit that is interrupting). By default, bits 0 (programming error), 1 (non-existent drive) and 2 (missed transfer) are interrupting. Bits 3 to 7 do not interrupt. The request stays high until its causes are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command issue strobe |
| cmdDrive | input | DRV_W | Target drive of the command |
| cmdIsData | input | 1 | 1 = data transfer command, 0 = non-data |
| cmdIsRead | input | 1 | Direction of a data command, 1 = read |
| byteCountZero | input | 1 | Byte count has reached zero |
| sectorEnd | input | 1 | End of the current sector |
| lastWordSent | input | 1 | Last word delivered to memory |
| errEvent | input | NUM_ERR | Error event pulses |
| errClrWe | input | 1 | Write-one-to-clear strobe for error bits |
| errClrMask | input | NUM_ERR | Error bits to clear |
| doneClrWe | input | 1 | Write-one-to-clear strobe for complete |
| attnIn | input | NUM_DRIVES | Drive attention levels |
| irqEnable | input | 1 | Interrupt enable |
| abortReq | input | 1 | Abort of the running transfer |
| initReq | input | 1 | Adapter initialise |
| cmdAccept | output | 1 | Command accepted this cycle |
| xferBusy | output | 1 | Transfer in progress |
| xferDone | output | 1 | Transfer complete |
| driveReady | output | NUM_DRIVES | Per-drive ready flags |
| errStatus | output | NUM_ERR | Sticky error bits |
| irqReq | output | 1 | Level interrupt request |

## Verification
The hardest situations to produce are the ones where two events meet in the same cycle. The bench applies an error event together with a clear of the same bit, a termination together with a clear of complete, and an init together with a fresh error. It also feeds a read transfer a sector-end pulse and an early last-word pulse, and both must be ignored. Each of these is set up by presenting the inputs for a single cycle at a known point in the transfer, and the status is then checked on the following edge.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // Strobes from the control half to the status datapath
  typedef struct packed {
    logic startXfer;
    logic endXfer;
    logic clearAll;
  } xfer_strobe_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [DRV_W-1:0] cmdDrive,
  input  logic             cmdIsData,
  input  logic             cmdIsRead,
  input  logic             byteCountZero,
  input  logic             sectorEnd,
  input  logic             lastWordSent,
  input  logic             abortReq,
  input  logic             initReq,
  input  logic [NUM_DRIVES-1:0] driveReady,
  output logic             cmdAccept,
  output logic             xferBusy,
  output logic [DRV_W-1:0] strobeDrive,
  output xfer_strobe_t     strobes
);
  logic             busyQ;
  logic             readQ;
  logic             zeroSeenQ;
  logic [DRV_W-1:0] driveQ;
  logic             endCond;
  logic             dirEnd;

  always_comb begin
    cmdAccept = cmdValid && !initReq && driveReady[cmdDrive]
                && (!cmdIsData || !busyQ);
    dirEnd    = readQ ? lastWordSent : sectorEnd;
    endCond   = (zeroSeenQ || byteCountZero) && dirEnd;
    strobes.clearAll  = initReq;
    strobes.startXfer = cmdAccept && cmdIsData;
    strobes.endXfer   = busyQ && !initReq && (abortReq || endCond);
    strobeDrive = strobes.startXfer ? cmdDrive : driveQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      readQ     <= 1'b0;
      zeroSeenQ <= 1'b0;
      driveQ    <= '0;
    end else if (strobes.clearAll) begin
      busyQ     <= 1'b0;
      zeroSeenQ <= 1'b0;
    end else if (strobes.startXfer) begin
      busyQ     <= 1'b1;
      readQ     <= cmdIsRead;
      driveQ    <= cmdDrive;
      zeroSeenQ <= 1'b0;
    end else if (strobes.endXfer) begin
      busyQ     <= 1'b0;
      zeroSeenQ <= 1'b0;
    end else if (busyQ && byteCountZero) begin
      zeroSeenQ <= 1'b1;
    end
  end

  assign xferBusy = busyQ;
endmodule

// File: rtl/xfer_status_dp.sv
module xfer_status_dp
  import xfer_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int NUM_ERR = 8,
  parameter logic [NUM_ERR-1:0] IRQ_ERR_MASK = 8'b0000_0111,
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xfer_strobe_t          strobes,
  input  logic [DRV_W-1:0]      strobeDrive,
  input  logic [NUM_ERR-1:0]    errEvent,
  input  logic                  errClrWe,
  input  logic [NUM_ERR-1:0]    errClrMask,
  input  logic                  doneClrWe,
  input  logic [NUM_DRIVES-1:0] attnIn,
  input  logic                  irqEnable,
  output logic                  xferDone,
  output logic [NUM_DRIVES-1:0] driveReady,
  output logic [NUM_ERR-1:0]    errStatus,
  output logic                  irqReq
);
  logic                  doneQ;
  logic [NUM_DRIVES-1:0] readyQ;
  logic [NUM_ERR-1:0]    errQ;
  logic [NUM_ERR-1:0]    errKeep;

  // One ready flag per drive
  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_ready
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) readyQ[d] <= 1'b1;
      else if (strobes.clearAll) readyQ[d] <= 1'b1;
      else if (strobes.startXfer && strobeDrive == DRV_W'(d)) readyQ[d] <= 1'b0;
      else if (strobes.endXfer && strobeDrive == DRV_W'(d)) readyQ[d] <= 1'b1;
    end
  end

  always_comb begin
    if (strobes.startXfer) errKeep = '0;
    else if (errClrWe)     errKeep = errQ & ~errClrMask;
    else                   errKeep = errQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ  <= '0;
      doneQ <= 1'b0;
    end else if (strobes.clearAll) begin
      errQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      errQ <= errKeep | errEvent;
      if (strobes.endXfer)                       doneQ <= 1'b1;
      else if (strobes.startXfer || doneClrWe)   doneQ <= 1'b0;
    end
  end

  assign irqReq     = irqEnable && (doneQ || (|attnIn) || (|(errQ & IRQ_ERR_MASK)));
  assign xferDone   = doneQ;
  assign driveReady = readyQ;
  assign errStatus  = errQ;
endmodule

// File: rtl/xfer_status_irq.sv
module xfer_status_irq
  import xfer_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int NUM_ERR = 8,
  parameter logic [NUM_ERR-1:0] IRQ_ERR_MASK = 8'b0000_0111,
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [DRV_W-1:0]      cmdDrive,
  input  logic                  cmdIsData,
  input  logic                  cmdIsRead,
  input  logic                  byteCountZero,
  input  logic                  sectorEnd,
  input  logic                  lastWordSent,
  input  logic [NUM_ERR-1:0]    errEvent,
  input  logic                  errClrWe,
  input  logic [NUM_ERR-1:0]    errClrMask,
  input  logic                  doneClrWe,
  input  logic [NUM_DRIVES-1:0] attnIn,
  input  logic                  irqEnable,
  input  logic                  abortReq,
  input  logic                  initReq,
  output logic                  cmdAccept,
  output logic                  xferBusy,
  output logic                  xferDone,
  output logic [NUM_DRIVES-1:0] driveReady,
  output logic [NUM_ERR-1:0]    errStatus,
  output logic                  irqReq
);
  xfer_strobe_t     strobes;
  logic [DRV_W-1:0] strobeDrive;

  xfer_ctrl #(.NUM_DRIVES(NUM_DRIVES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdDrive(cmdDrive),
    .cmdIsData(cmdIsData), .cmdIsRead(cmdIsRead),
    .byteCountZero(byteCountZero), .sectorEnd(sectorEnd),
    .lastWordSent(lastWordSent), .abortReq(abortReq), .initReq(initReq),
    .driveReady(driveReady), .cmdAccept(cmdAccept), .xferBusy(xferBusy),
    .strobeDrive(strobeDrive), .strobes(strobes)
  );

  xfer_status_dp #(.NUM_DRIVES(NUM_DRIVES), .NUM_ERR(NUM_ERR),
                   .IRQ_ERR_MASK(IRQ_ERR_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .strobeDrive(strobeDrive),
    .errEvent(errEvent), .errClrWe(errClrWe), .errClrMask(errClrMask),
    .doneClrWe(doneClrWe), .attnIn(attnIn), .irqEnable(irqEnable),
    .xferDone(xferDone), .driveReady(driveReady), .errStatus(errStatus),
    .irqReq(irqReq)
  );
endmodule

// File: rtl/xfer_status_checker.sv
module xfer_status_checker #(
  parameter int NUM_DRIVES = 4,
  parameter int NUM_ERR = 8,
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [DRV_W-1:0]      cmdDrive,
  input logic                  cmdIsData,
  input logic [NUM_ERR-1:0]    errEvent,
  input logic                  irqEnable,
  input logic                  abortReq,
  input logic                  initReq,
  input logic                  cmdAccept,
  input logic                  xferBusy,
  input logic                  xferDone,
  input logic [NUM_DRIVES-1:0] driveReady,
  input logic [NUM_ERR-1:0]    errStatus,
  input logic                  irqReq
);
  a_r2_accept_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    cmdAccept |-> driveReady[cmdDrive]);

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAccept && cmdIsData) |=> (xferBusy && !driveReady[$past(cmdDrive)]));

  a_r4_end_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(xferBusy) && !$past(initReq)) |-> xferDone);

  a_r6_abort_ends: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && xferBusy && !initReq) |=> (!xferBusy && xferDone));

  a_r7_init_clears: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> (!xferBusy && !xferDone && errStatus == '0 && (&driveReady)));

  a_r8_event_sticks: assert property (@(posedge clk) disable iff (!rstN)
    ((|errEvent) && !initReq) |=> ((errStatus & $past(errEvent)) == $past(errEvent)));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqEnable);

  a_r10_done_irq: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && xferDone) |-> irqReq);
endmodule

bind xfer_status_irq xfer_status_checker #(.NUM_DRIVES(NUM_DRIVES), .NUM_ERR(NUM_ERR)) u_chk (
  .clk(clk), .rstN(rstN), .cmdDrive(cmdDrive), .cmdIsData(cmdIsData),
  .errEvent(errEvent), .irqEnable(irqEnable), .abortReq(abortReq),
  .initReq(initReq), .cmdAccept(cmdAccept), .xferBusy(xferBusy),
  .xferDone(xferDone), .driveReady(driveReady), .errStatus(errStatus),
  .irqReq(irqReq)
);

// File: tb/test_xfer_status_irq.sv
module test_xfer_status_irq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 0, cmdIsData = 0, cmdIsRead = 0;
  logic [1:0] cmdDrive = '0;
  logic       byteCountZero = 0, sectorEnd = 0, lastWordSent = 0;
  logic [7:0] errEvent = '0, errClrMask = '0;
  logic       errClrWe = 0, doneClrWe = 0;
  logic [3:0] attnIn = '0;
  logic       irqEnable = 0, abortReq = 0, initReq = 0;
  logic       cmdAccept, xferBusy, xferDone, irqReq;
  logic [3:0] driveReady;
  logic [7:0] errStatus;

  int checks = 0;
  int fails = 0;

  typedef struct {
    string      tag;
    logic       busy;
    logic       done;
    logic [3:0] ready;
    logic [7:0] err;
    logic       irq;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  xfer_status_irq i_xfer_status_irq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdDrive(cmdDrive),
    .cmdIsData(cmdIsData), .cmdIsRead(cmdIsRead), .byteCountZero(byteCountZero),
    .sectorEnd(sectorEnd), .lastWordSent(lastWordSent), .errEvent(errEvent),
    .errClrWe(errClrWe), .errClrMask(errClrMask), .doneClrWe(doneClrWe),
    .attnIn(attnIn), .irqEnable(irqEnable), .abortReq(abortReq),
    .initReq(initReq), .cmdAccept(cmdAccept), .xferBusy(xferBusy),
    .xferDone(xferDone), .driveReady(driveReady), .errStatus(errStatus),
    .irqReq(irqReq)
  );

  // Monitor: compares status 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (xferBusy !== e.busy || xferDone !== e.done || driveReady !== e.ready ||
            errStatus !== e.err || irqReq !== e.irq) begin
          fails++;
          $display("FAIL %s: got busy=%b done=%b ready=%b err=%h irq=%b, expected busy=%b done=%b ready=%b err=%h irq=%b",
                   e.tag, xferBusy, xferDone, driveReady, errStatus, irqReq,
                   e.busy, e.done, e.ready, e.err, e.irq);
        end
      end
    end
  end

  // Driver: inputs already applied at a falling edge; push expectation, go to next falling edge
  task automatic tick(input string tag, input logic b, input logic d,
                      input logic [3:0] r, input logic [7:0] er, input logic iq);
    exp_t e;
    e.tag = tag; e.busy = b; e.done = d; e.ready = r; e.err = er; e.irq = iq;
    sbq.push_back(e);
    @(negedge clk);
    cmdValid = 0; byteCountZero = 0; sectorEnd = 0; lastWordSent = 0;
    errEvent = '0; errClrWe = 0; errClrMask = '0; doneClrWe = 0;
    abortReq = 0; initReq = 0;
  endtask

  task automatic chk_accept(input string tag, input logic expAcc);
    #1;
    checks++;
    if (cmdAccept !== expAcc) begin
      fails++;
      $display("FAIL %s: cmdAccept got %b expected %b", tag, cmdAccept, expAcc);
    end
  endtask

  task automatic issue(input logic [1:0] drv, input logic isData, input logic isRead);
    cmdValid = 1; cmdDrive = drv; cmdIsData = isData; cmdIsRead = isRead;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick("R1 reset state", 0, 0, 4'b1111, 8'h00, 0);
    irqEnable = 1;

    // Read on drive 2
    issue(2, 1, 1); chk_accept("R2 data accept idle", 1);
    tick("R3 read start", 1, 0, 4'b1011, 8'h00, 0);
    lastWordSent = 1;
    tick("R5 early last word", 1, 0, 4'b1011, 8'h00, 0);
    issue(1, 0, 0); chk_accept("R2 non-data while busy", 1);
    tick("R2 non-data no effect", 1, 0, 4'b1011, 8'h00, 0);
    issue(1, 1, 0); chk_accept("R2 data while busy", 0);
    tick("R2 rejected data", 1, 0, 4'b1011, 8'h00, 0);
    issue(2, 0, 0); chk_accept("R2 non-data drive not ready", 0);
    tick("R2 rejected non-data", 1, 0, 4'b1011, 8'h00, 0);
    byteCountZero = 1;
    tick("R4 count zero only", 1, 0, 4'b1011, 8'h00, 0);
    sectorEnd = 1;
    tick("R4 sector end ignored on read", 1, 0, 4'b1011, 8'h00, 0);
    lastWordSent = 1;
    tick("R4 read ends", 0, 1, 4'b1111, 8'h00, 1);
    doneClrWe = 1;
    tick("R9 clear done", 0, 0, 4'b1111, 8'h00, 0);

    // Write on drive 0, zero and sector end in one cycle
    issue(0, 1, 0); chk_accept("R2 write accept", 1);
    tick("R3 write start", 1, 0, 4'b1110, 8'h00, 0);
    byteCountZero = 1; sectorEnd = 1; doneClrWe = 1;
    tick("R4 R9 write ends over clear", 0, 1, 4'b1111, 8'h00, 1);
    doneClrWe = 1;
    tick("R9 clear done again", 0, 0, 4'b1111, 8'h00, 0);

    // Error bits
    errEvent = 8'h08;
    tick("R10 non-interrupting error", 0, 0, 4'b1111, 8'h08, 0);
    errEvent = 8'h01;
    tick("R10 interrupting error", 0, 0, 4'b1111, 8'h09, 1);
    errEvent = 8'h01; errClrWe = 1; errClrMask = 8'h01;
    tick("R8 event beats clear", 0, 0, 4'b1111, 8'h09, 1);
    errClrWe = 1; errClrMask = 8'h09;
    tick("R8 write one clears", 0, 0, 4'b1111, 8'h00, 0);
    errEvent = 8'h20;
    tick("R8 set bit 5", 0, 0, 4'b1111, 8'h20, 0);
    issue(3, 1, 1); chk_accept("R2 accept drive 3", 1);
    tick("R3 start clears errors", 1, 0, 4'b0111, 8'h00, 0);
    errEvent = 8'h08;
    tick("R8 error during transfer", 1, 0, 4'b0111, 8'h08, 0);
    abortReq = 1;
    tick("R6 abort ends keeps errors", 0, 1, 4'b1111, 8'h08, 1);
    abortReq = 1; doneClrWe = 1;
    tick("R6 abort idle no effect", 0, 0, 4'b1111, 8'h08, 0);

    // Attention and enable
    attnIn = 4'b0100;
    tick("R10 attention raises irq", 0, 0, 4'b1111, 8'h08, 1);
    irqEnable = 0;
    tick("R10 enable gates irq", 0, 0, 4'b1111, 8'h08, 0);
    attnIn = 4'b0000; irqEnable = 1;

    // Init
    issue(1, 1, 0); chk_accept("R2 accept drive 1", 1);
    tick("R3 start drive 1", 1, 0, 4'b1101, 8'h00, 0);
    errEvent = 8'h04;
    tick("R8 missed transfer", 1, 0, 4'b1101, 8'h04, 1);
    initReq = 1; errEvent = 8'h02; issue(0, 0, 0); chk_accept("R7 init blocks accept", 0);
    tick("R7 init clears all", 0, 0, 4'b1111, 8'h00, 0);

    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule